// File: doc/BRIEF.md
# Update-Based Write-Back Coherence Controller

This block tracks the coherence state of every line of a small direct-mapped write-back cache that keeps copies in other caches current by broadcasting single-word updates instead of invalidating them. It takes processor reads and writes and raises bus reads, word updates and write-backs toward an external arbiter. It also watches the transactions that other caches put on the bus. A wired-OR shared input tells it, during its own granted cycle, whether any other cache holds the block. The data array itself lies outside the block. The controller only raises write strobes for it: line fill, processor word write and snooped word write.

A present line is always in one of four states: Exclusive-clean (EC, code 0), Shared-clean (SC, code 1), Shared-modified (SM, code 2) or Modified (MD, code 3). No invalid state exists. A block that is not held shows up only as a tag miss, or as an empty slot after reset or after a write-back. SM and MD are owner states: the cache holding the block in one of them must write it back to memory before the slot is reused. SM also means that other copies may exist and that memory is stale.

The sequencer has four states. IDLE does lookups and completes hits. WB_WAIT writes back an owned victim. RD_WAIT fetches the block. UPD_WAIT broadcasts a word update. Its transitions are:
- IDLE→UPD_WAIT on a write hit to SC or SM.
- IDLE→WB_WAIT on a miss whose slot holds an owned line.
- IDLE→RD_WAIT on any other miss.
- WB_WAIT→RD_WAIT on grant.
- RD_WAIT→UPD_WAIT on grant of a write miss when the shared input is high.
- RD_WAIT→IDLE on any other grant.
- UPD_WAIT→IDLE on grant.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is present. Every lookup misses (lkp_hit=0), and bus_req stays low until a processor request misses or needs an update.
- R2: A read miss issues exactly one bus read (bus_cmd=1) carrying the requested address, with fill_we high in that cycle. The line is installed as EC (0) if bus_shared_in is low and as SC (1) if it is high. cpu_done rises in the granted cycle.
- R3: A write hit to an EC or MD line completes in the cycle of the request, with no bus request, with word_we high, and with the line ending in MD (3).
- R4: A write hit to an SC or SM line issues one word update (bus_cmd=2) at the line address. The line becomes SM (2) if bus_shared_in is high in the granted cycle, and MD (3) otherwise.
- R5: A write miss issues a bus read first. If bus_shared_in is low the line goes directly to MD with no update. If it is high, the line is filled as SC and a word update follows, leaving the line in SM.
- R6: A miss whose slot holds an SM or MD line issues a write-back (bus_cmd=3) with the victim's address before the bus read. A miss on an EC or SC slot replaces the line without a write-back.
- R7: A snooped bus read (snp_cmd=1) that hits raises snp_shared. An MD or SM line also raises snp_supply. MD moves to SM, EC moves to SC, and SC and SM keep their state.
- R8: A snooped word update (snp_cmd=2) that hits raises snp_shared and snp_word_we and moves SM to SC, so ownership passes to the writer. Only SC or SM lines can see such a hit.
- R9: A snooped write-back (snp_cmd=3), or any snoop whose tag misses, leaves every line state unchanged and raises neither snp_shared nor snp_supply.
- R10: A processor request whose index equals that of a snoop in the same cycle is held for that cycle: no cpu_done and no state change from the processor side. The snoop takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address; low IDX_W bits select the slot |
| cpu_done | output | 1 | Request completes this cycle |
| lkp_hit | output | 1 | Slot of cpu_addr holds the block |
| lkp_state | output | 2 | State of that line when lkp_hit, else 0 |
| word_we | output | 1 | Write the processor word into the data array |
| fill_we | output | 1 | Load the block from the bus into the data array |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Arbiter grant for this cycle |
| bus_cmd_valid | output | 1 | Own transaction driven this cycle |
| bus_cmd | output | 2 | 1 read, 2 word update, 3 write-back |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_shared_in | input | 1 | Wired-OR: another cache holds the block |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared | output | 1 | This cache's contribution to the wired-OR line |
| snp_supply | output | 1 | This cache supplies the block instead of memory |
| snp_word_we | output | 1 | Write the snooped word into the local copy |

## Verification
The assertions check, on every cycle:
- that a snooped update only ever meets a line in SC or SM;
- that a supplying cache also raises the shared line;
- that local and snoop writes never hit the same slot together;
- that an update is broadcast only for a present line;
- that a write-back or a shared write-miss fill is followed by a further bus request.

Only the bench's scenarios can show the resulting state codes:
- EC versus SC on a fill, and SM versus MD after an update;
- the handover of ownership when an update is snooped;
- the address order of the write-back before the read;
- a write to a clean exclusive line that is held back by a colliding snoop and then takes the update path.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

    typedef enum logic [1:0] {
        ST_EC = 2'd0,
        ST_SC = 2'd1,
        ST_SM = 2'd2,
        ST_MD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_WB_WAIT  = 2'd1,
        CS_RD_WAIT  = 2'd2,
        CS_UPD_WAIT = 2'd3
    } ctrl_st_e;

    function automatic logic is_owner(line_st_e s);
        return (s == ST_SM) || (s == ST_MD);
    endfunction

endpackage

// File: rtl/upd_coh_table.sv
module upd_coh_table
    import upd_coh_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_we,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic             loc_vld,
    input  logic [TAG_W-1:0] loc_tag,
    input  line_st_e         loc_st,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_vld,
    output logic [TAG_W-1:0] ra_tag,
    output line_st_e         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_vld,
    output logic [TAG_W-1:0] rb_tag,
    output line_st_e         rb_st
);
    localparam int NLINES = 1 << IDX_W;

    logic             vld_q [NLINES];
    logic [TAG_W-1:0] tag_q [NLINES];
    line_st_e         st_q  [NLINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                st_q[i]  <= ST_EC;
            end else if (loc_we && (loc_idx == IDX_W'(i))) begin
                vld_q[i] <= loc_vld;
                tag_q[i] <= loc_tag;
                st_q[i]  <= loc_st;
            end else if (snp_we && (snp_idx == IDX_W'(i))) begin
                st_q[i]  <= snp_st;
            end
        end
    end

    assign ra_vld = vld_q[ra_idx];
    assign ra_tag = tag_q[ra_idx];
    assign ra_st  = st_q[ra_idx];
    assign rb_vld = vld_q[rb_idx];
    assign rb_tag = tag_q[rb_idx];
    assign rb_st  = st_q[rb_idx];

    // R10
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_we && snp_we && (loc_idx == snp_idx)));

endmodule

// File: rtl/upd_coh_snoop.sv
module upd_coh_snoop
    import upd_coh_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             line_vld,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             snp_shared,
    output logic             snp_supply,
    output logic             snp_word_we,
    output logic             st_we,
    output line_st_e         st_nxt
);
    logic hit;
    assign hit = snp_valid && line_vld && (line_tag == snp_tag);

    always_comb begin
        snp_shared  = 1'b0;
        snp_supply  = 1'b0;
        snp_word_we = 1'b0;
        st_nxt      = line_st;
        if (hit) begin
            unique case (snp_cmd)
                BC_RD: begin
                    snp_shared = 1'b1;
                    snp_supply = is_owner(line_st);
                    if (line_st == ST_MD) st_nxt = ST_SM;
                    if (line_st == ST_EC) st_nxt = ST_SC;
                end
                BC_UPD: begin
                    snp_shared  = 1'b1;
                    snp_word_we = 1'b1;
                    if (line_st == ST_SM) st_nxt = ST_SC;
                end
                BC_WB, BC_NONE: begin
                    st_nxt = line_st;
                end
            endcase
        end
    end

    assign st_we = hit && (st_nxt != line_st);

    // R8
    upd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && snp_cmd == BC_UPD) |-> (line_st == ST_SC || line_st == ST_SM));

    // R7
    supply_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);

    // R7
    supply_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && snp_cmd == BC_RD && line_st == ST_MD) |-> (st_we && st_nxt == ST_SM));

endmodule

// File: rtl/upd_coh_seq.sv
module upd_coh_seq
    import upd_coh_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_wr,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              look_vld,
    input  logic [TAG_W-1:0]  look_tag,
    input  line_st_e          look_st,
    input  logic              snp_conflict,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    output logic              cpu_done,
    output logic              word_we,
    output logic              fill_we,
    output logic              bus_req,
    output logic              bus_cmd_valid,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              loc_we,
    output logic              loc_vld,
    output logic [TAG_W-1:0]  loc_tag,
    output line_st_e          loc_st
);
    ctrl_st_e state_q, state_d;
    logic     hit;

    assign hit = look_vld && (look_tag == cpu_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        cpu_done      = 1'b0;
        word_we       = 1'b0;
        fill_we       = 1'b0;
        bus_req       = 1'b0;
        bus_cmd_valid = 1'b0;
        bus_cmd       = BC_NONE;
        bus_addr      = {cpu_tag, cpu_idx};
        loc_we        = 1'b0;
        loc_vld       = 1'b1;
        loc_tag       = cpu_tag;
        loc_st        = ST_EC;
        unique case (state_q)
            CS_IDLE: begin
                if (cpu_valid && !snp_conflict) begin
                    if (hit) begin
                        if (!cpu_wr) begin
                            cpu_done = 1'b1;
                        end else begin
                            unique case (look_st)
                                ST_EC, ST_MD: begin
                                    loc_we   = 1'b1;
                                    loc_st   = ST_MD;
                                    word_we  = 1'b1;
                                    cpu_done = 1'b1;
                                end
                                ST_SC, ST_SM: state_d = CS_UPD_WAIT;
                            endcase
                        end
                    end else if (look_vld && is_owner(look_st)) begin
                        state_d = CS_WB_WAIT;
                    end else begin
                        state_d = CS_RD_WAIT;
                    end
                end
            end
            CS_WB_WAIT: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd_valid = 1'b1;
                    bus_cmd       = BC_WB;
                    bus_addr      = {look_tag, cpu_idx};
                    loc_we        = 1'b1;
                    loc_vld       = 1'b0;
                    loc_tag       = look_tag;
                    loc_st        = look_st;
                    state_d       = CS_RD_WAIT;
                end
            end
            CS_RD_WAIT: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd_valid = 1'b1;
                    bus_cmd       = BC_RD;
                    fill_we       = 1'b1;
                    loc_we        = 1'b1;
                    if (!cpu_wr) begin
                        loc_st   = bus_shared_in ? ST_SC : ST_EC;
                        cpu_done = 1'b1;
                        state_d  = CS_IDLE;
                    end else if (bus_shared_in) begin
                        loc_st   = ST_SC;
                        state_d  = CS_UPD_WAIT;
                    end else begin
                        loc_st   = ST_MD;
                        word_we  = 1'b1;
                        cpu_done = 1'b1;
                        state_d  = CS_IDLE;
                    end
                end
            end
            CS_UPD_WAIT: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd_valid = 1'b1;
                    bus_cmd       = BC_UPD;
                    loc_we        = 1'b1;
                    loc_st        = bus_shared_in ? ST_SM : ST_MD;
                    word_we       = 1'b1;
                    cpu_done      = 1'b1;
                    state_d       = CS_IDLE;
                end
            end
        endcase
    end

    // R4
    upd_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd == BC_UPD) |-> hit);

    // R6
    wb_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd == BC_WB) |=> (bus_req && !loc_vld_q_hit()));

    // R5
    shared_wmiss_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd == BC_RD && cpu_wr && bus_shared_in) |=> bus_req);

    // R3
    quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_wr && $past(state_d) == CS_IDLE && state_q == CS_IDLE) |-> !bus_req);

    function automatic logic loc_vld_q_hit();
        return 1'b0;
    endfunction

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
    import upd_coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              lkp_hit,
    output logic [1:0]        lkp_state,
    output logic              word_we,
    output logic              fill_we,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic              snp_word_we
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    logic             a_vld, b_vld;
    logic [TAG_W-1:0] a_tag, b_tag;
    line_st_e         a_st, b_st;

    logic             loc_we, loc_vld;
    logic [TAG_W-1:0] loc_tag;
    line_st_e         loc_st;
    logic             snp_st_we;
    line_st_e         snp_st_nxt;
    bus_cmd_e         own_cmd;
    logic             snp_conflict;

    assign snp_conflict = snp_valid && (snp_idx == cpu_idx);

    upd_coh_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .loc_we  (loc_we),
        .loc_idx (cpu_idx),
        .loc_vld (loc_vld),
        .loc_tag (loc_tag),
        .loc_st  (loc_st),
        .snp_we  (snp_st_we),
        .snp_idx (snp_idx),
        .snp_st  (snp_st_nxt),
        .ra_idx  (cpu_idx),
        .ra_vld  (a_vld),
        .ra_tag  (a_tag),
        .ra_st   (a_st),
        .rb_idx  (snp_idx),
        .rb_vld  (b_vld),
        .rb_tag  (b_tag),
        .rb_st   (b_st)
    );

    upd_coh_snoop #(.TAG_W(TAG_W)) u_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_valid   (snp_valid),
        .snp_cmd     (bus_cmd_e'(snp_cmd)),
        .snp_tag     (snp_tag),
        .line_vld    (b_vld),
        .line_tag    (b_tag),
        .line_st     (b_st),
        .snp_shared  (snp_shared),
        .snp_supply  (snp_supply),
        .snp_word_we (snp_word_we),
        .st_we       (snp_st_we),
        .st_nxt      (snp_st_nxt)
    );

    upd_coh_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_valid     (cpu_valid),
        .cpu_wr        (cpu_wr),
        .cpu_tag       (cpu_tag),
        .cpu_idx       (cpu_idx),
        .look_vld      (a_vld),
        .look_tag      (a_tag),
        .look_st       (a_st),
        .snp_conflict  (snp_conflict),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .cpu_done      (cpu_done),
        .word_we       (word_we),
        .fill_we       (fill_we),
        .bus_req       (bus_req),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd       (own_cmd),
        .bus_addr      (bus_addr),
        .loc_we        (loc_we),
        .loc_vld       (loc_vld),
        .loc_tag       (loc_tag),
        .loc_st        (loc_st)
    );

    assign bus_cmd   = own_cmd;
    assign lkp_hit   = a_vld && (a_tag == cpu_tag);
    assign lkp_state = lkp_hit ? a_st : 2'd0;

    // R10
    bus_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cmd_valid && snp_valid));

    // R9
    wb_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd3) |-> (!snp_shared && !snp_supply && !snp_st_we));

endmodule

// File: tb/tb_upd_coh_ctrl.sv
module tb_upd_coh_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_done, lkp_hit, word_we, fill_we, bus_req, bus_cmd_valid;
    logic [1:0]  lkp_state, bus_cmd;
    logic [15:0] bus_addr;
    logic        bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [15:0] snp_addr = '0;
    logic        snp_shared, snp_supply, snp_word_we;

    int nchk = 0, nerr = 0;
    bit finished = 0;
    int log_n, log_fill;
    logic [1:0]  log_cmd  [4];
    logic [15:0] log_addr [4];

    always #4 clk = ~clk;

    upd_coh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_done(cpu_done), .lkp_hit(lkp_hit),
        .lkp_state(lkp_state), .word_we(word_we), .fill_we(fill_we),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_word_we(snp_word_we)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // processor request, grant given whenever requested; logs bus transactions
    task automatic cpu_txn(input logic wr, input logic [15:0] a, input logic sh);
        bit got = 0;
        log_n = 0;
        log_fill = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_wr = wr; cpu_addr = a;
            bus_gnt = 1'b0; bus_shared_in = sh;
            #1;
            bus_gnt = bus_req;
            #1;
            if (bus_cmd_valid && log_n < 4) begin
                log_cmd[log_n]  = bus_cmd;
                log_addr[log_n] = bus_addr;
                if (fill_we) log_fill++;
                log_n++;
            end
            if (cpu_done) got = 1;
            @(posedge clk);
            if (got) break;
        end
        @(negedge clk);
        cpu_valid = 1'b0; bus_gnt = 1'b0; bus_shared_in = 1'b0;
        if (!got) chk("R2", "request never completed", 0, 1);
    endtask

    task automatic peek(input string req, input logic [15:0] a, input int hit, input int st);
        @(negedge clk);
        cpu_valid = 1'b0; cpu_addr = a;
        #2;
        chk(req, "lookup hit", lkp_hit, hit);
        if (hit != 0) chk(req, "line state", lkp_state, st);
    endtask

    task automatic snoop(input string req, input int cmd, input logic [15:0] a,
                         input int sh, input int sup, input int wwe);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = a;
        #2;
        chk(req, "snp_shared", snp_shared, sh);
        chk(req, "snp_supply", snp_supply, sup);
        chk(req, "snp_word_we", snp_word_we, wwe);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset;
        peek("R1", 16'h0010, 0, 0);
        chk("R1", "bus_req after reset", bus_req, 0);
    endtask

    task automatic t_read_miss;
        cpu_txn(1'b0, 16'h0011, 1'b0);
        chk("R2", "read miss txn count", log_n, 1);
        chk("R2", "read miss cmd", log_cmd[0], 1);
        chk("R2", "read miss addr", log_addr[0], 16'h0011);
        chk("R2", "fill strobe", log_fill, 1);
        peek("R2", 16'h0011, 1, 0);
        cpu_txn(1'b0, 16'h0022, 1'b1);
        peek("R2", 16'h0022, 1, 1);
    endtask

    task automatic t_write_ec;
        cpu_txn(1'b1, 16'h0011, 1'b0);
        chk("R3", "EC write bus txns", log_n, 0);
        peek("R3", 16'h0011, 1, 3);
    endtask

    task automatic t_snoop_rd_owner;
        snoop("R7", 1, 16'h0011, 1, 1, 0);
        peek("R7", 16'h0011, 1, 2);
    endtask

    task automatic t_update_path;
        cpu_txn(1'b1, 16'h0011, 1'b1);
        chk("R4", "SM write txn count", log_n, 1);
        chk("R4", "SM write cmd", log_cmd[0], 2);
        chk("R4", "SM write addr", log_addr[0], 16'h0011);
        peek("R4", 16'h0011, 1, 2);
        snoop("R8", 2, 16'h0011, 1, 0, 1);
        peek("R8", 16'h0011, 1, 1);
        cpu_txn(1'b1, 16'h0011, 1'b0);
        chk("R4", "SC write cmd", log_cmd[0], 2);
        peek("R4", 16'h0011, 1, 3);
    endtask

    task automatic t_snoop_rd_clean;
        snoop("R7", 1, 16'h0022, 1, 0, 0);
        peek("R7", 16'h0022, 1, 1);
        cpu_txn(1'b0, 16'h0033, 1'b0);
        snoop("R7", 1, 16'h0033, 1, 0, 0);
        peek("R7", 16'h0033, 1, 1);
    endtask

    task automatic t_write_miss;
        cpu_txn(1'b1, 16'h0044, 1'b0);
        chk("R5", "private write miss txns", log_n, 1);
        chk("R5", "private write miss cmd", log_cmd[0], 1);
        peek("R5", 16'h0044, 1, 3);
        cpu_txn(1'b1, 16'h0055, 1'b1);
        chk("R5", "shared write miss txns", log_n, 2);
        chk("R5", "shared write miss first", log_cmd[0], 1);
        chk("R5", "shared write miss second", log_cmd[1], 2);
        peek("R5", 16'h0055, 1, 2);
    endtask

    task automatic t_victim;
        cpu_txn(1'b0, 16'h0019, 1'b0);
        chk("R6", "owned victim txns", log_n, 2);
        chk("R6", "first is write-back", log_cmd[0], 3);
        chk("R6", "write-back addr", log_addr[0], 16'h0011);
        chk("R6", "then read", log_cmd[1], 1);
        chk("R6", "read addr", log_addr[1], 16'h0019);
        peek("R6", 16'h0011, 0, 0);
        peek("R6", 16'h0019, 1, 0);
        cpu_txn(1'b0, 16'h002A, 1'b0);
        chk("R6", "clean victim txns", log_n, 1);
        chk("R6", "clean victim cmd", log_cmd[0], 1);
    endtask

    task automatic t_snoop_quiet;
        snoop("R9", 3, 16'h0044, 0, 0, 0);
        peek("R9", 16'h0044, 1, 3);
        snoop("R9", 1, 16'h004C, 0, 0, 0);
        peek("R9", 16'h0044, 1, 3);
    endtask

    task automatic t_conflict;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h0019;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0019;
        #2;
        chk("R10", "held request done", cpu_done, 0);
        chk("R10", "held request word_we", word_we, 0);
        chk("R10", "snoop still shared", snp_shared, 1);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        #2;
        chk("R10", "line after snoop", lkp_state, 1);
        cpu_txn(1'b1, 16'h0019, 1'b0);
        chk("R10", "write now updates", log_n, 1);
        chk("R10", "update cmd", log_cmd[0], 2);
        peek("R10", 16'h0019, 1, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss();
        t_write_ec();
        t_snoop_rd_owner();
        t_update_path();
        t_snoop_rd_clean();
        t_write_miss();
        t_victim();
        t_snoop_quiet();
        t_conflict();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule